// File: doc/BRIEF.md
# Strobe Delay-Lock Digital Controller

This block is the digital half of a delay-locked loop that places a memory read strobe at a chosen phase. Each reference clock cycle, a phase detector outside the block reports whether the delay line is early or late. When the step enable is high, the block moves a 7-bit delay setting one step in that direction. The setting is kept in Gray code, so that only one control wire to the delay line toggles per step. The setting stops at the ends of its range and never wraps. The block also reports lock once a fixed settling time has passed since the last reset. Software picks that time, long or short, through a mode input.

A second path builds an adjusted code for the strobe logic. It takes the current setting, adds or subtracts a 7-bit offset, and limits the result to the legal code range. Downstream logic may only take up a new code on a periodic update pulse. For that reason both the plain code and the adjusted code are published only at the end of an update cycle. Between pulses they hold. A reset can come from core logic or from a pin, and the two have the same effect.

Top module: `dll_delay_ctrl`

## Requirements
- R1: When `rst_n` or `pin_rst_n` is low at a rising clock edge, the setting becomes 64, `delay_gray` becomes 7'b1100000, `delay_code` and `offset_code` become 64, `locked` becomes 0, and the update phase restarts. Either reset input alone has this full effect.
- R2: At an edge with `step_en`=1, the setting rises by one if `step_up`=1 and falls by one if `step_up`=0. With `step_en`=0 it holds.
- R3: `delay_gray` always equals the Gray encoding of the setting (value XOR value shifted right by one). Consecutive values differ in at most one bit.
- R4: The setting saturates. An up step at 127 leaves it at 127, and a down step at 0 leaves it at 0.
- R5: `locked` is 1 exactly when at least 2560 edges have passed since reset release with `low_jitter`=1, or at least 512 edges with `low_jitter`=0. Once high, it stays high while the mode is unchanged, until the next reset.
- R6: The adjusted value is the setting plus `offset_in` when `offset_add`=1, and the setting minus `offset_in` when `offset_add`=0. The result is limited to 0..127.
- R7: `update_pulse` is high for one cycle out of every 8. The first pulse comes in the cycle after the seventh edge following reset release.
- R8: `delay_code` and `offset_code` load only at the edge that ends a cycle in which `update_pulse` is high. They take the setting and the adjusted value (R6) present in that cycle, and otherwise they hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset from core logic |
| pin_rst_n | input | 1 | Synchronous active-low reset from a pin |
| low_jitter | input | 1 | 1 selects the 2560-cycle lock wait, 0 selects 512 |
| step_en | input | 1 | Apply the phase decision on this cycle |
| step_up | input | 1 | Phase decision: 1 lengthens delay, 0 shortens |
| offset_in | input | 7 | Phase offset magnitude |
| offset_add | input | 1 | 1 adds the offset, 0 subtracts it |
| delay_gray | output | 7 | Live Gray-coded delay setting to the delay line |
| delay_code | output | 7 | Published binary delay setting |
| offset_code | output | 7 | Published offset-adjusted delay setting |
| update_pulse | output | 1 | Marks the cycles on which published codes may change |
| locked | output | 1 | Lock wait has elapsed |

## Verification
Several properties are checked by assertions on every cycle. These are the single-bit change of the Gray state, holding with the enable low, saturation at both ends, the spacing of the update pulse, lock staying high, and the published codes staying still off the pulse. Other behaviours need the bench's scenarios and its cycle-accurate model. These are the exact edge at which lock rises in each mode, the clamped offset results, the values loaded at each pulse, and the equivalence of the two reset sources.

// File: rtl/dll_ctrl_pkg.sv
// Shared code width, code limits and Gray conversion helpers for the
// delay-lock controller. Assumes a code width of at least 2 bits.
package dll_ctrl_pkg;
    localparam int CODE_W   = 7;
    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int CODE_MID = 1 << (CODE_W - 1);

    typedef logic [CODE_W-1:0] code_t;

    // Binary to Gray
    function automatic code_t to_gray(input code_t b);
        return b ^ (b >> 1);
    endfunction

    // Gray to binary, MSB first
    function automatic code_t from_gray(input code_t g);
        code_t b;
        b[CODE_W-1] = g[CODE_W-1];
        for (int i = CODE_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/dll_gray_step.sv
// Saturating up/down counter whose state register holds Gray code.
// Assumes rst is synchronous and already combined from all sources.
module dll_gray_step
    import dll_ctrl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step_en,
    input  logic  step_up,
    output code_t gray_q,
    output code_t bin_val
);
    localparam code_t TOP = code_t'(CODE_MAX);
    localparam code_t MID = code_t'(CODE_MID);

    code_t bin_nxt;

    assign bin_val = from_gray(gray_q);

    // Next binary value with saturation at both ends
    always_comb begin
        bin_nxt = bin_val;
        if (step_en) begin
            if (step_up && bin_val != TOP)
                bin_nxt = bin_val + code_t'(1);
            else if (!step_up && bin_val != '0)
                bin_nxt = bin_val - code_t'(1);
        end
    end

    // Gray state register, mid-scale on reset
    always_ff @(posedge clk) begin
        if (rst) gray_q <= to_gray(MID);
        else     gray_q <= to_gray(bin_nxt);
    end

    AST_GRAY_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        $countones(gray_q ^ $past(gray_q)) <= 1); // R3
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(gray_q)); // R2
    AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst)
        (bin_val == TOP && step_up) |=> bin_val == TOP); // R4
    AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (rst)
        (bin_val == '0 && !step_up) |=> bin_val == '0); // R4
endmodule

// File: rtl/dll_lock_timer.sv
// Counts reference edges since reset and flags lock once the wait for
// the selected mode has elapsed. Assumes LONG_WAIT >= SHORT_WAIT.
module dll_lock_timer #(
    parameter int LONG_WAIT  = 2560,
    parameter int SHORT_WAIT = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic low_jitter,
    output logic locked
);
    localparam int CNT_W = $clog2(LONG_WAIT + 1);
    localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_WAIT);
    localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_WAIT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Edge counter, saturating at the long wait
    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (cnt_q != LONG_C) cnt_q <= cnt_q + 1'b1;
    end

    // Mode selects the threshold
    always_comb begin
        limit  = low_jitter ? LONG_C : SHORT_C;
        locked = (cnt_q >= limit);
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        (locked && $stable(low_jitter)) |=> (locked || $changed(low_jitter))); // R5
endmodule

// File: rtl/dll_update_tick.sv
// Free-running phase counter giving a one-cycle update pulse every
// PERIOD cycles, the first after PERIOD-1 edges. Assumes PERIOD >= 2.
module dll_update_tick #(
    parameter int PERIOD = 8
) (
    input  logic clk,
    input  logic rst,
    output logic pulse
);
    localparam int PH_W = $clog2(PERIOD);
    localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

    logic [PH_W-1:0] ph_q;

    // Phase counter, wraps after the last phase
    always_ff @(posedge clk) begin
        if (rst)             ph_q <= '0;
        else if (ph_q == LAST) ph_q <= '0;
        else                 ph_q <= ph_q + 1'b1;
    end

    assign pulse = (ph_q == LAST);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse); // R7
endmodule

// File: rtl/dll_offset_stage.sv
// Adds or subtracts a phase offset from the delay code and clamps the
// result to the legal code range. Purely combinational.
module dll_offset_stage
    import dll_ctrl_pkg::*;
(
    input  code_t code_in,
    input  code_t offset_in,
    input  logic  offset_add,
    output code_t code_out
);
    localparam int EXT_W = CODE_W + 2;
    localparam logic signed [EXT_W-1:0] HI = EXT_W'(CODE_MAX);

    logic signed [EXT_W-1:0] sum;

    // Widened signed arithmetic then clamp
    always_comb begin
        if (offset_add)
            sum = $signed({2'b00, code_in}) + $signed({2'b00, offset_in});
        else
            sum = $signed({2'b00, code_in}) - $signed({2'b00, offset_in});
        if (sum < 0)       code_out = '0;
        else if (sum > HI) code_out = code_t'(CODE_MAX);
        else               code_out = sum[CODE_W-1:0];
    end

    always_comb begin
        AST_CLAMP_ADD: assert (!offset_add || code_out >= code_in); // R6
    end
endmodule

// File: rtl/dll_delay_ctrl.sv
// Digital controller of a strobe delay-locked loop: Gray-coded
// saturating delay setting, mode-selected lock wait, periodic update
// pulse and an offset-adjusted code. Both reset inputs are synchronous,
// active-low and equivalent.
module dll_delay_ctrl
    import dll_ctrl_pkg::*;
#(
    parameter int LONG_WAIT  = 2560,
    parameter int SHORT_WAIT = 512,
    parameter int UPD_PERIOD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_rst_n,
    input  logic              low_jitter,
    input  logic              step_en,
    input  logic              step_up,
    input  logic [CODE_W-1:0] offset_in,
    input  logic              offset_add,
    output logic [CODE_W-1:0] delay_gray,
    output logic [CODE_W-1:0] delay_code,
    output logic [CODE_W-1:0] offset_code,
    output logic              update_pulse,
    output logic              locked
);
    localparam code_t MID = code_t'(CODE_MID);

    logic  rst;
    code_t cur_bin;
    code_t adj_code;

    assign rst = !rst_n || !pin_rst_n;

    dll_gray_step u_step (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .step_up (step_up),
        .gray_q  (delay_gray),
        .bin_val (cur_bin)
    );

    dll_lock_timer #(
        .LONG_WAIT  (LONG_WAIT),
        .SHORT_WAIT (SHORT_WAIT)
    ) u_lock (
        .clk        (clk),
        .rst        (rst),
        .low_jitter (low_jitter),
        .locked     (locked)
    );

    dll_update_tick #(
        .PERIOD (UPD_PERIOD)
    ) u_tick (
        .clk   (clk),
        .rst   (rst),
        .pulse (update_pulse)
    );

    dll_offset_stage u_ofs (
        .code_in    (cur_bin),
        .offset_in  (offset_in),
        .offset_add (offset_add),
        .code_out   (adj_code)
    );

    // Publish both codes only at the end of an update cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            delay_code  <= MID;
            offset_code <= MID;
        end else if (update_pulse) begin
            delay_code  <= cur_bin;
            offset_code <= adj_code;
        end
    end

    AST_PUBLISH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !update_pulse |=> ($stable(delay_code) && $stable(offset_code))); // R8
endmodule

// File: tb/sim_dll_delay_ctrl.sv
// Cycle-accurate behavioural model compared against the controller.
module sim_dll_delay_ctrl;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_rst_n = 1'b1;
    logic       low_jitter = 1'b0;
    logic       step_en = 1'b0;
    logic       step_up = 1'b0;
    logic [6:0] offset_in = '0;
    logic       offset_add = 1'b0;
    logic [6:0] delay_gray, delay_code, offset_code;
    logic       update_pulse, locked;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    int m_set = 64, m_ph = 0, m_cnt = 0, m_code = 64, m_off = 64;

    always #(CLK_P/2) clk = ~clk;

    dll_delay_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n),
        .low_jitter(low_jitter), .step_en(step_en), .step_up(step_up),
        .offset_in(offset_in), .offset_add(offset_add),
        .delay_gray(delay_gray), .delay_code(delay_code),
        .offset_code(offset_code), .update_pulse(update_pulse),
        .locked(locked)
    );

    function automatic int clamp_adj(int s, int o, bit add);
        int v;
        v = add ? s + o : s - o;
        if (v < 0) v = 0;
        if (v > 127) v = 127;
        return v;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n || !pin_rst_n) begin
            m_set = 64; m_ph = 0; m_cnt = 0; m_code = 64; m_off = 64;
        end else begin
            if (m_ph == 7) begin
                m_code = m_set;
                m_off  = clamp_adj(m_set, int'(offset_in), offset_add);
            end
            if (step_en) begin
                if (step_up && m_set < 127) m_set++;
                else if (!step_up && m_set > 0) m_set--;
            end
            m_ph = (m_ph + 1) % 8;
            if (m_cnt < 2560) m_cnt++;
        end
    end

    // Compare every cycle, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (!done) begin
            chk("R2 R4 delay setting via gray", int'(delay_gray), m_set ^ (m_set >> 1));
            chk("R3 gray encoding", int'(delay_gray), m_set ^ (m_set >> 1));
            chk("R8 delay_code", int'(delay_code), m_code);
            chk("R6 offset_code", int'(offset_code), m_off);
            chk("R7 update_pulse", int'(update_pulse), int'(m_ph == 7));
            chk("R5 locked", int'(locked), int'(m_cnt >= (low_jitter ? 2560 : 512)));
        end
    end

    task automatic run_rand(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step_en    = ($urandom % 4) != 0;
            step_up    = $urandom % 2;
            offset_in  = 7'($urandom);
            offset_add = $urandom % 2;
        end
    endtask

    task automatic run_fixed(int n, bit en, bit up, int ofs, bit add);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step_en = en; step_up = up; offset_in = 7'(ofs); offset_add = add;
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: logic reset, short mode
        repeat (3) @(negedge clk);
        chk("R1 reset gray", int'(delay_gray), 7'b1100000);
        chk("R1 reset locked", int'(locked), 0);
        rst_n = 1'b1;
        run_rand(700);                  // R2 R5 R7 R8 mixed traffic, lock at 512
        run_fixed(150, 1, 1, 100, 1);   // R4 top saturation, R6 clamp high
        run_fixed(16, 0, 0, 20, 0);     // R2 hold, R6 subtract
        run_fixed(200, 1, 0, 5, 0);     // R4 bottom saturation, R6 clamp low
        run_fixed(16, 1, 0, 127, 1);    // R6 add at bottom
        // R1: pin reset alone, long mode
        @(negedge clk);
        pin_rst_n = 1'b0; low_jitter = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 pin reset code", int'(delay_code), 64);
        chk("R1 pin reset offset", int'(offset_code), 64);
        chk("R1 pin reset locked", int'(locked), 0);
        pin_rst_n = 1'b1;
        run_rand(2700);                 // R5 long wait boundary
        @(negedge clk);
        chk("R5 locked after long wait", int'(locked), 1);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule